// File: doc/BRIEF.md
# Memory-Mapped BCD Real-Time Clock

This block is a byte-wide static memory with a timekeeping counter chain inside it. The top sixteen addresses of the space form a register window. It holds the time, the alarm settings, a control byte and an alarm flag byte. Every address below the window is ordinary read/write storage. The port is a synchronous SRAM-style port with chip enable, write enable, output enable, an address and separate data-in and data-out buses. A data-valid output tells the system when to drive the shared bus. The address is `ADDR_W` bits wide. A setting of 13 gives the full 8192-word array.

A 100 Hz tick enable advances a packed-BCD counter chain. The chain runs through hundredths, seconds, minutes, hours (24-hour), day of week, date, month and two-digit year, and it applies leap years. Each time the hundredths wrap, the whole chain is copied into the time registers. Accesses to plain storage never wait on the copy. Software sets the time by raising the set bit, writing the time registers, then clearing the set bit, which loads the chain. It gets a stable reading by raising the hold bit. An alarm on seconds, minutes, hours and date drives a level interrupt. A power-fail input deselects the block.

Top module: `bcd_rtc_sram`

## Requirements
- R1: Reads and writes below the register window act as plain memory. Read data and `data_oe_o` appear one clock after the read is sampled with `ce_i`=1, `we_i`=0, `oe_i`=1.
- R2: Window offsets (address low 4 bits, upper bits all ones) map as follows: 0 hundredths, 1 seconds, 2 alarm seconds, 3 minutes, 4 alarm minutes, 5 hours, 6 alarm hours, 7 day of week, 8 date, 9 alarm date, A month, B year, C control, D flags, E and F scratch. Every offset except D reads back what was written.
- R3: On each tick the chain counts in BCD. Hundredths wrap 99 to 00, seconds and minutes wrap 59 to 00, and hours wrap 23 to 00. Day of week runs 1 to 7 and advances with the date.
- R4: Date ends at 31, 30 (months 04, 06, 09, 11) or February's 28/29, then wraps to 01 and advances the month. Month 12 wraps to 01 and advances the year, and year 99 wraps to 00. A year whose BCD value is divisible by 4, including 00, is a leap year.
- R5: The time registers take the chain value once per second, in the cycle after the hundredths wrap. Control bit 0 (hold) blocks this copy while the chain keeps counting.
- R6: Writing control with bit 1 (set) going from 1 to 0 loads the time registers into the chain. While set is 1, the once-per-second copy is blocked.
- R7: At each once-per-second update, the alarm flag (flags bit 0) sets when seconds, minutes, hours and date all match their alarm registers. Bit 7 of an alarm register removes that field from the match. `irq_o` equals the flag ANDed with control bit 2.
- R8: A read of the flags register returns the flag and clears it.
- R9: While `pwr_fail_i` is 1, writes are ignored and `data_oe_o` stays 0.
- R10: A counter field holding an illegal BCD digit becomes its lowest legal value at the next carry into it, without carrying further.
- R11: After reset, date, month and day of week read 01. Control, all other time fields and the alarm registers read 00, and `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_i | input | 1 | Chip enable |
| we_i | input | 1 | Write enable (1 = write) |
| oe_i | input | 1 | Output enable |
| addr_i | input | ADDR_W | Word address |
| data_i | input | 8 | Write data |
| data_o | output | 8 | Read data |
| data_oe_o | output | 1 | Read data valid, drive the bus |
| tick_i | input | 1 | 100 Hz count enable, one cycle wide |
| pwr_fail_i | input | 1 | Supply out of tolerance |
| irq_o | output | 1 | Alarm interrupt, active high level |

## Verification
A wrong count or rollover in the chain stays hidden until the next wrap of the hundredths. It then shows one cycle later as a bad value in the time registers, so each vector forces exactly one wrap and reads every field back. A wrong leap or month-length decision shows only on the last date of a month. A stuck flag shows on `irq_o` one cycle after the update and survives a flags read. A leak in the power-fail gating shows up as a changed byte on the first read after power returns.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
package rtc_pkg;

  typedef struct packed {
    logic [7:0] year;
    logic [7:0] month;
    logic [7:0] date;
    logic [7:0] dow;
    logic [7:0] hour;
    logic [7:0] min;
    logic [7:0] sec;
    logic [7:0] hund;
  } rtc_time_t;

  localparam rtc_time_t TIME_RST = '{year: 8'h00, month: 8'h01, date: 8'h01, dow: 8'h01,
                                     hour: 8'h00, min: 8'h00, sec: 8'h00, hund: 8'h00};

  localparam logic [3:0] OFF_HUND  = 4'h0;
  localparam logic [3:0] OFF_SEC   = 4'h1;
  localparam logic [3:0] OFF_ASEC  = 4'h2;
  localparam logic [3:0] OFF_MIN   = 4'h3;
  localparam logic [3:0] OFF_AMIN  = 4'h4;
  localparam logic [3:0] OFF_HOUR  = 4'h5;
  localparam logic [3:0] OFF_AHOUR = 4'h6;
  localparam logic [3:0] OFF_DOW   = 4'h7;
  localparam logic [3:0] OFF_DATE  = 4'h8;
  localparam logic [3:0] OFF_ADATE = 4'h9;
  localparam logic [3:0] OFF_MONTH = 4'hA;
  localparam logic [3:0] OFF_YEAR  = 4'hB;
  localparam logic [3:0] OFF_CTRL  = 4'hC;
  localparam logic [3:0] OFF_FLAG  = 4'hD;

  localparam int unsigned CTL_HOLD = 0;
  localparam int unsigned CTL_SET  = 1;
  localparam int unsigned CTL_AIE  = 2;

  // {carry, next}; illegal digits snap to lo without carry (R10)
  function automatic logic [8:0] bcd_inc(input logic [7:0] v, input logic [7:0] lo,
                                         input logic [7:0] hi);
    logic [8:0] r;
    if (v[3:0] > 4'd9 || v[7:4] > 4'd9) r = {1'b0, lo};
    else if (v >= hi)                   r = {1'b1, lo};
    else if (v[3:0] == 4'd9)            r = {1'b0, v[7:4] + 4'd1, 4'd0};
    else                                r = {1'b0, v + 8'd1};
    return r;
  endfunction

  function automatic logic [7:0] month_last(input logic [7:0] m, input logic [7:0] y);
    logic [1:0] s;
    s = y[1:0] + {y[4], 1'b0};  // BCD year mod 4, since 10 = 2 mod 4
    case (m)
      8'h02:                      return (s == 2'd0) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_chain.sv
`timescale 1ns/1ps
module rtc_chain
  import rtc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      tick_i,
  input  logic      load_i,
  input  rtc_time_t ld_time_i,
  output rtc_time_t time_o,
  output logic      sec_strobe_o
);

  rtc_time_t  t_q, t_n;
  logic [8:0] r_c;
  logic       wrap_c;

  always_comb begin
    t_n    = t_q;
    r_c    = bcd_inc(t_q.hund, 8'h00, 8'h99);
    t_n.hund = r_c[7:0];
    wrap_c = r_c[8];
    if (wrap_c) begin
      r_c = bcd_inc(t_q.sec, 8'h00, 8'h59);
      t_n.sec = r_c[7:0];
      if (r_c[8]) begin
        r_c = bcd_inc(t_q.min, 8'h00, 8'h59);
        t_n.min = r_c[7:0];
        if (r_c[8]) begin
          r_c = bcd_inc(t_q.hour, 8'h00, 8'h23);
          t_n.hour = r_c[7:0];
          if (r_c[8]) begin
            r_c = bcd_inc(t_q.dow, 8'h01, 8'h07);
            t_n.dow = r_c[7:0];
            r_c = bcd_inc(t_q.date, 8'h01, month_last(t_q.month, t_q.year));
            t_n.date = r_c[7:0];
            if (r_c[8]) begin
              r_c = bcd_inc(t_q.month, 8'h01, 8'h12);
              t_n.month = r_c[7:0];
              if (r_c[8]) begin
                r_c = bcd_inc(t_q.year, 8'h00, 8'h99);
                t_n.year = r_c[7:0];
              end
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t_q          <= TIME_RST;
      sec_strobe_o <= 1'b0;
    end else begin
      if (load_i)      t_q <= ld_time_i;
      else if (tick_i) t_q <= t_n;
      sec_strobe_o <= tick_i & ~load_i & wrap_c;
    end
  end

  assign time_o = t_q;

  assert_hund_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i && t_q.hund == 8'h99) |=> (t_q.hund == 8'h00 && sec_strobe_o));

  assert_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (t_q == $past(ld_time_i)));

endmodule

// File: rtl/rtc_alarm.sv
`timescale 1ns/1ps
module rtc_alarm
  import rtc_pkg::*;
#(
  parameter int unsigned NFIELD = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 strobe_i,
  input  logic                 clr_i,
  input  logic [NFIELD-1:0][7:0] cur_i,
  input  logic [NFIELD-1:0][7:0] alm_i,
  output logic                 flag_o
);

  logic [NFIELD-1:0] hit;

  for (genvar g = 0; g < NFIELD; g++) begin : g_field
    assign hit[g] = alm_i[g][7] | ({1'b0, alm_i[g][6:0]} == cur_i[g]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               flag_o <= 1'b0;
    else if (strobe_i && &hit) flag_o <= 1'b1;
    else if (clr_i)            flag_o <= 1'b0;
  end

  assert_flag_at_update_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> $past(strobe_i));

  assert_read_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !strobe_i) |=> !flag_o);

endmodule

// File: rtl/rtc_ram.sv
`timescale 1ns/1ps
module rtc_ram #(
  parameter int unsigned AW = 11
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o
);

  localparam int unsigned DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[addr_i] <= wdata_i;
    if (re_i) rdata_o <= mem[addr_i];
  end

endmodule

// File: rtl/bcd_rtc_sram.sv
`timescale 1ns/1ps
module bcd_rtc_sram
  import rtc_pkg::*;
#(
  parameter int unsigned ADDR_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_i,
  input  logic              we_i,
  input  logic              oe_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  output logic [7:0]        data_o,
  output logic              data_oe_o,
  input  logic              tick_i,
  input  logic              pwr_fail_i,
  output logic              irq_o
);

  localparam int unsigned WIN_W = 4;
  localparam int unsigned NREG  = 1 << WIN_W;

  logic [WIN_W-1:0] off;
  logic             in_win, sel, wr, rd;
  logic [7:0]       regs [NREG];
  rtc_time_t        now, ld_time;
  logic             strobe, refresh, load_q, flag, flag_rd;
  logic             rd_vld_q, win_sel_q;
  logic [7:0]       win_q, ram_q;
  logic [3:0][7:0]  alm_cur, alm_set;

  assign off    = addr_i[WIN_W-1:0];
  assign in_win = &addr_i[ADDR_W-1:WIN_W];
  assign sel    = ce_i & ~pwr_fail_i;
  assign wr     = sel & we_i;
  assign rd     = sel & ~we_i;

  assign refresh = strobe & ~regs[OFF_CTRL][CTL_HOLD] & ~regs[OFF_CTRL][CTL_SET];
  assign flag_rd = rd & in_win & (off == OFF_FLAG);

  assign ld_time = '{year: regs[OFF_YEAR], month: regs[OFF_MONTH], date: regs[OFF_DATE],
                     dow: regs[OFF_DOW], hour: regs[OFF_HOUR], min: regs[OFF_MIN],
                     sec: regs[OFF_SEC], hund: regs[OFF_HUND]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs[i] <= 8'h00;
      regs[OFF_DATE]  <= 8'h01;
      regs[OFF_MONTH] <= 8'h01;
      regs[OFF_DOW]   <= 8'h01;
      load_q          <= 1'b0;
    end else begin
      if (refresh) begin
        regs[OFF_HUND]  <= now.hund;
        regs[OFF_SEC]   <= now.sec;
        regs[OFF_MIN]   <= now.min;
        regs[OFF_HOUR]  <= now.hour;
        regs[OFF_DOW]   <= now.dow;
        regs[OFF_DATE]  <= now.date;
        regs[OFF_MONTH] <= now.month;
        regs[OFF_YEAR]  <= now.year;
      end
      // software write wins over the once-per-second copy
      if (wr && in_win && off != OFF_FLAG) regs[off] <= data_i;
      load_q <= wr & in_win & (off == OFF_CTRL) & regs[OFF_CTRL][CTL_SET] & ~data_i[CTL_SET];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_vld_q  <= 1'b0;
      win_sel_q <= 1'b0;
      win_q     <= 8'h00;
    end else begin
      rd_vld_q <= rd & oe_i;
      if (rd) begin
        win_sel_q <= in_win;
        win_q     <= (off == OFF_FLAG) ? {7'd0, flag} : regs[off];
      end
    end
  end

  rtc_ram #(.AW(ADDR_W)) u_ram (
    .clk_i   (clk_i),
    .we_i    (wr & ~in_win),
    .re_i    (rd & ~in_win),
    .addr_i  (addr_i),
    .wdata_i (data_i),
    .rdata_o (ram_q)
  );

  rtc_chain u_chain (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick_i),
    .load_i       (load_q),
    .ld_time_i    (ld_time),
    .time_o       (now),
    .sec_strobe_o (strobe)
  );

  assign alm_cur = {now.date, now.hour, now.min, now.sec};
  assign alm_set = {regs[OFF_ADATE], regs[OFF_AHOUR], regs[OFF_AMIN], regs[OFF_ASEC]};

  rtc_alarm #(.NFIELD(4)) u_alarm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (strobe),
    .clr_i    (flag_rd),
    .cur_i    (alm_cur),
    .alm_i    (alm_set),
    .flag_o   (flag)
  );

  assign data_o    = win_sel_q ? win_q : ram_q;
  assign data_oe_o = rd_vld_q & ~pwr_fail_i;
  assign irq_o     = flag & regs[OFF_CTRL][CTL_AIE];

  assert_pf_ctrl_frozen_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_fail_i |=> $stable(regs[OFF_CTRL]));

endmodule

// File: tb/sim_bcd_rtc_sram.sv
`timescale 1ns/1ps
module sim_bcd_rtc_sram;

  localparam int unsigned AW = 11;
  localparam logic [AW-1:0] WB = 11'h7F0;
  localparam int NV = 16;
  // y mo da dw h mi s | expected y mo da dw h mi s after one second
  localparam logic [111:0] VEC [NV] = '{
    112'h23_01_15_03_10_20_30_23_01_15_03_10_20_31,
    112'h23_01_15_03_10_20_59_23_01_15_03_10_21_00,
    112'h23_01_15_03_10_59_59_23_01_15_03_11_00_00,
    112'h23_01_15_07_23_59_59_23_01_16_01_00_00_00,
    112'h23_01_31_02_23_59_59_23_02_01_03_00_00_00,
    112'h23_02_28_02_23_59_59_23_03_01_03_00_00_00,
    112'h24_02_28_03_23_59_59_24_02_29_04_00_00_00,
    112'h24_02_29_04_23_59_59_24_03_01_05_00_00_00,
    112'h23_04_30_01_23_59_59_23_05_01_02_00_00_00,
    112'h99_12_31_05_23_59_59_00_01_01_06_00_00_00,
    112'h00_02_28_01_23_59_59_00_02_29_02_00_00_00,
    112'h23_09_30_06_23_59_59_23_10_01_07_00_00_00,
    112'h23_01_15_03_10_20_3C_23_01_15_03_10_20_00,
    112'h22_02_28_01_23_59_59_22_03_01_02_00_00_00,
    112'h23_06_09_03_23_59_59_23_06_10_04_00_00_00,
    112'h23_01_15_03_1A_59_59_23_01_15_03_00_00_00
  };
  localparam logic [3:0] FOFF [7] = '{4'hB, 4'hA, 4'h8, 4'h7, 4'h5, 4'h3, 4'h1};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce = 1'b0, we = 1'b0, oe = 1'b0, tick = 1'b0, pf = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    din = 8'h00;
  logic [7:0]    dout;
  logic          doe, irq;
  int            n_chk = 0, n_err = 0;

  always #5 clk = ~clk;

  bcd_rtc_sram #(.ADDR_W(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ce_i(ce), .we_i(we), .oe_i(oe), .addr_i(addr),
    .data_i(din), .data_o(dout), .data_oe_o(doe), .tick_i(tick),
    .pwr_fail_i(pf), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); ce = 1'b1; we = 1'b1; oe = 1'b0; addr = a; din = d;
    @(negedge clk); ce = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d, output logic v);
    @(negedge clk); ce = 1'b1; we = 1'b0; oe = 1'b1; addr = a;
    @(negedge clk); d = dout; v = doe; ce = 1'b0; oe = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [AW-1:0] a, input logic [7:0] exp);
    logic [7:0] d;
    logic v;
    rd(a, d, v);
    chk(tag, d, exp);
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic set_time(input logic [55:0] t, input logic [7:0] ctl);
    wr(WB + 11'hC, 8'h02);
    wr(WB + 11'h0, 8'h99);
    for (int k = 0; k < 7; k++) wr(WB + AW'(FOFF[k]), t[55-8*k -: 8]);
    wr(WB + 11'hC, ctl);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk("R11 irq", {7'd0, irq}, 8'h00);
    chk("R11 oe idle", {7'd0, doe}, 8'h00);
    rd_chk("R11 month", WB + 11'hA, 8'h01);
    rd_chk("R11 date", WB + 11'h8, 8'h01);
    rd_chk("R11 dow", WB + 11'h7, 8'h01);
    rd_chk("R11 ctrl", WB + 11'hC, 8'h00);
    rd_chk("R11 sec", WB + 11'h1, 8'h00);
    rd_chk("R11 alarm sec", WB + 11'h2, 8'h00);

    // R1 plain memory, R2 scratch registers
    wr(11'h000, 8'h5A);
    wr(11'h123, 8'hC3);
    wr(11'h7EF, 8'h3C);
    wr(WB + 11'hE, 8'h77);
    wr(WB + 11'hF, 8'h88);
    rd(11'h000, d, v);
    chk("R1 data addr 000", d, 8'h5A);
    chk("R1 data valid", {7'd0, v}, 8'h01);
    rd_chk("R1 addr 123", 11'h123, 8'hC3);
    rd_chk("R1 addr below window", 11'h7EF, 8'h3C);
    rd_chk("R2 scratch E", WB + 11'hE, 8'h77);
    rd_chk("R2 scratch F", WB + 11'hF, 8'h88);
    wr(WB + 11'h6, 8'h85);
    rd_chk("R2 alarm hours readback", WB + 11'h6, 8'h85);
    wr(WB + 11'h6, 8'h80);

    // vector table: R3 R4 R10 counting, R5 refresh, R6 load
    for (int i = 0; i < NV; i++) begin
      set_time(VEC[i][111:56], 8'h00);
      ticks(1);
      for (int k = 0; k < 7; k++)
        rd_chk($sformatf("R3 R4 R5 R6 R10 vec %0d field %0d", i, k),
               WB + AW'(FOFF[k]), VEC[i][55-8*k -: 8]);
    end

    // R5 hold blocks refresh while counting continues
    set_time(56'h23_01_15_03_10_20_30, 8'h01);
    ticks(1);
    rd_chk("R5 held sec", WB + 11'h1, 8'h30);
    wr(WB + 11'hC, 8'h00);
    ticks(100);
    rd_chk("R5 released sec", WB + 11'h1, 8'h32);
    rd_chk("R5 hundredths at refresh", WB + 11'h0, 8'h00);

    // R7 alarm on seconds, R8 read clear
    wr(WB + 11'h2, 8'h31);
    wr(WB + 11'h4, 8'h80);
    wr(WB + 11'h9, 8'h80);
    set_time(56'h23_01_15_03_10_20_30, 8'h04);
    chk("R7 irq before match", {7'd0, irq}, 8'h00);
    ticks(1);
    chk("R7 irq on match", {7'd0, irq}, 8'h01);
    rd_chk("R8 flag read", WB + 11'hD, 8'h01);
    chk("R8 irq after read", {7'd0, irq}, 8'h00);
    rd_chk("R8 flag cleared", WB + 11'hD, 8'h00);

    // R7 no match
    wr(WB + 11'h2, 8'h45);
    set_time(56'h23_01_15_03_10_20_30, 8'h04);
    ticks(1);
    chk("R7 irq on mismatch", {7'd0, irq}, 8'h00);

    // R7 masked seconds, match on minutes
    wr(WB + 11'h2, 8'h80);
    wr(WB + 11'h4, 8'h21);
    set_time(56'h23_01_15_03_10_20_59, 8'h00);
    ticks(1);
    chk("R7 masked irq disabled", {7'd0, irq}, 8'h00);
    rd_chk("R7 flag with irq disabled", WB + 11'hD, 8'h01);

    // R9 power fail
    wr(WB + 11'hC, 8'h04);
    wr(11'h005, 8'h11);
    @(negedge clk); pf = 1'b1;
    wr(11'h005, 8'hAA);
    wr(WB + 11'hC, 8'h07);
    rd(11'h005, d, v);
    chk("R9 no drive in power fail", {7'd0, v}, 8'h00);
    @(negedge clk); pf = 1'b0;
    rd_chk("R9 ram write ignored", 11'h005, 8'h11);
    rd_chk("R9 ctrl write ignored", WB + 11'hC, 8'h04);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule